// File: doc/BRIEF.md
# Single-Cycle Subset Processor

This block is a 32-bit processor core that completes one instruction every clock cycle. It supports nine instructions: word load, word store, add, subtract, AND, OR, set-on-less-than, branch-if-equal and jump. Each cycle, the program counter selects a word from a private instruction store. The core then decodes that word and reads two general registers. An arithmetic unit computes a result, a data address or an equality test. Finally, the core commits at most one write to either the register bank or the private data store, and picks the next program counter.

Both stores are small word arrays inside the core. While reset is held, the surrounding logic fills them through a single preload port that can target either array. Every architectural effect of the current instruction appears combinationally on output ports during its cycle, before the clock edge commits it:

- the program counter and the fetched word;
- the register write enable, index and value;
- the store enable, address and value;
- the signed-overflow flag.

Top module: `sc_core`

## Requirements
- R1: While the synchronous reset `rst` is high, the program counter is forced to 0 at each clock edge. No register or store write is reported or performed. All 32 registers read as 0 after reset.
- R2: Any instruction other than a taken branch or a jump advances the program counter by 4.
- R3: Opcode 000000 is the register-form group. Funct 100000 adds, 100010 subtracts, 100100 ANDs and 100101 ORs. The operands are the registers named by bits 25-21 and 20-16, and the result goes to the register named by bits 15-11. `ovf_o` flags two's-complement overflow of add and subtract without blocking the write.
- R4: Funct 101010 writes 1 when the first operand is less than the second as signed numbers, and 0 otherwise.
- R5: Opcode 100011 loads the data word at index (base + sign-extended bits 15-0)[DAW+1:2] into the register named by bits 20-16. The base is the register named by bits 25-21.
- R6: Opcode 101011 writes the register named by bits 20-16 to the data word at the same computed address. `st_en`, `st_addr` and `st_data` report the write, and no register is written.
- R7: Opcode 000100 compares the two source registers. When they are equal, the next program counter is PC+4 plus the sign-extended bits 15-0 shifted left by 2. Otherwise it is PC+4. Nothing is written.
- R8: Opcode 000010 sets the next program counter to bits 31-28 of PC+4 joined with bits 25-0 of the instruction and two zero bits. Nothing is written.
- R9: Register 0 always reads 0. A write aimed at it is dropped and not reported on `wb_en`.
- R10: Any other opcode, and register-form words with any other funct, write nothing and advance the program counter by 4.
- R11: The preload port writes `ld_data` at the next clock edge: to instruction word `ld_addr` when `ld_dmem` is 0, or to data word `ld_addr` when it is 1. Fetch reads instruction word PC[IAW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction store, 1 data store |
| ld_addr | input | LAW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Word fetched at the current program counter |
| wb_en | output | 1 | Register write happens at the coming edge |
| wb_addr | output | 5 | Register index being written |
| wb_data | output | 32 | Value being written |
| st_en | output | 1 | Data store write happens at the coming edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |
| ovf_o | output | 1 | Signed overflow of the current arithmetic operation |

## Verification
The write and overflow outputs for an instruction are combinational from the current program counter and state, so they are due in the same cycle. The bench samples them one time unit after the falling edge that precedes the committing rising edge. Register and store updates only become visible one cycle later, through the operands of later instructions. The program-counter consequences of a branch or jump are checked at the next falling edge, after one register stage. A reference model advances exactly once per sampled cycle. Its results therefore line up with the design's single register stage, and each check compares against the instruction the model is executing at that moment.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_LOAD = 6'b100011;
    localparam logic [5:0] OPC_STOR = 6'b101011;
    localparam logic [5:0] OPC_BREQ = 6'b000100;
    localparam logic [5:0] OPC_JUMP = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // class of ALU use chosen by the main decoder
    typedef enum logic [1:0] {
        USE_ADD   = 2'b00,
        USE_SUB   = 2'b01,
        USE_FUNCT = 2'b10
    } alu_use_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'd0,
        ALU_OR  = 3'd1,
        ALU_ADD = 3'd2,
        ALU_SUB = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic dst_rd;   // destination from bits 15-11 instead of 20-16
        logic src_imm;  // second ALU operand is the extended immediate
        logic wb_mem;   // writeback value comes from the data store
        logic reg_we;
        logic mem_we;
        logic branch;
        logic jump;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_fn_e    fn
);

    alu_use_e use_d;
    logic     funct_ok_d;
    ctrl_t    base_d;

    // main decoder
    always_comb begin
        base_d = '0;
        use_d  = USE_ADD;
        unique case (opc)
            OPC_REG: begin
                base_d.dst_rd = 1'b1;
                base_d.reg_we = 1'b1;
                use_d         = USE_FUNCT;
            end
            OPC_LOAD: begin
                base_d.src_imm = 1'b1;
                base_d.wb_mem  = 1'b1;
                base_d.reg_we  = 1'b1;
            end
            OPC_STOR: begin
                base_d.src_imm = 1'b1;
                base_d.mem_we  = 1'b1;
            end
            OPC_BREQ: begin
                base_d.branch = 1'b1;
                use_d         = USE_SUB;
            end
            OPC_JUMP: begin
                base_d.jump = 1'b1;
            end
            default: begin
                base_d = '0;
            end
        endcase
    end

    // secondary ALU decoder
    always_comb begin
        funct_ok_d = 1'b1;
        fn         = ALU_ADD;
        case (use_d)
            USE_ADD: fn = ALU_ADD;
            USE_SUB: fn = ALU_SUB;
            USE_FUNCT: begin
                case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: begin
                        fn         = ALU_ADD;
                        funct_ok_d = 1'b0;
                    end
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end

    always_comb begin
        ctl        = base_d;
        ctl.reg_we = base_d.reg_we & funct_ok_d;
    end

    always_comb begin
        if (!(opc inside {OPC_REG, OPC_LOAD, OPC_STOR, OPC_BREQ, OPC_JUMP})) begin
            assert_unsup_quiet_R10: assert (!ctl.reg_we && !ctl.mem_we && !ctl.branch && !ctl.jump)
                else $error("unsupported opcode produced an effect");
        end
        assert_single_effect_R6: assert ($onehot0({ctl.reg_we, ctl.mem_we, ctl.branch, ctl.jump}))
            else $error("decoder asserted more than one effect");
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero,
    output logic            ovf
);

    logic [XLEN-1:0] sum_d;
    logic [XLEN-1:0] dif_d;
    logic            lt_d;

    always_comb begin
        sum_d = a + b;
        dif_d = a - b;
        lt_d  = $signed(a) < $signed(b);
        ovf   = 1'b0;
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: begin
                y   = sum_d;
                ovf = (a[XLEN-1] == b[XLEN-1]) && (sum_d[XLEN-1] != a[XLEN-1]);
            end
            ALU_SUB: begin
                y   = dif_d;
                ovf = (a[XLEN-1] != b[XLEN-1]) && (dif_d[XLEN-1] != a[XLEN-1]);
            end
            ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_d};
            default: y = sum_d;
        endcase
        zero = (y == '0);
    end

    always_comb begin
        if (fn == ALU_SLT) begin
            assert_slt_boolean_R4: assert (y[XLEN-1:1] == '0)
                else $error("set-less-than produced a non-boolean value");
        end
        if (fn == ALU_AND || fn == ALU_OR) begin
            assert_logic_no_overflow_R3: assert (!ovf)
                else $error("logic operation flagged overflow");
        end
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

    assert_zero_reg_kept_R9: assert property (@(posedge clk) disable iff (rst)
        regs_q[0] == '0)
        else $error("register 0 changed");

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs_q[$past(wa)] == $past(wd))
        else $error("register write lost");

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            wb_en,
    output logic [4:0]      wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            st_en,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic            ovf_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    logic [4:0]      rs, rt, rd, wb_dst;
    logic [15:0]     imm;
    logic [XLEN-1:0] sext, rd1, rd2, alu_b, alu_y, mem_rd, wb_val;
    logic [XLEN-1:0] pc4, br_tgt, j_tgt;
    logic            alu_zero, alu_ovf, take_br, reg_wr, mem_wr;
    ctrl_t           ctl;
    alu_fn_e         fn;

    // fetch and field split
    assign instr = imem_q[st_q.pc[IAW+1:2]];
    assign rs    = instr[25:21];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign imm   = instr[15:0];
    assign sext  = {{(XLEN-16){imm[15]}}, imm};

    sc_decode u_decode (
        .opc   (instr[31:26]),
        .funct (instr[5:0]),
        .ctl   (ctl),
        .fn    (fn)
    );

    sc_regfile #(.NREGS(32)) u_regs (
        .clk (clk),
        .rst (rst),
        .ra1 (rs),
        .ra2 (rt),
        .we  (reg_wr),
        .wa  (wb_dst),
        .wd  (wb_val),
        .rd1 (rd1),
        .rd2 (rd2)
    );

    assign alu_b = ctl.src_imm ? sext : rd2;

    sc_alu u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    // memory stage and writeback select
    assign mem_rd = dmem_q[alu_y[DAW+1:2]];
    assign wb_dst = ctl.dst_rd ? rd : rt;
    assign wb_val = ctl.wb_mem ? mem_rd : alu_y;
    assign reg_wr = !rst && ctl.reg_we && (wb_dst != 5'd0);
    assign mem_wr = !rst && ctl.mem_we;

    // next program counter
    assign pc4     = st_q.pc + 32'd4;
    assign br_tgt  = pc4 + {sext[XLEN-3:0], 2'b00};
    assign j_tgt   = {pc4[31:28], instr[25:0], 2'b00};
    assign take_br = ctl.branch && alu_zero;

    always_comb begin
        st_d = st_q;
        if (ctl.jump) begin
            st_d.pc = j_tgt;
        end else if (take_br) begin
            st_d.pc = br_tgt;
        end else begin
            st_d.pc = pc4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // stores: execution store takes priority over the preload port
    always_ff @(posedge clk) begin
        if (mem_wr) begin
            dmem_q[alu_y[DAW+1:2]] <= rd2;
        end else if (ld_we && ld_dmem) begin
            dmem_q[ld_addr[DAW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_we && !ld_dmem) begin
            imem_q[ld_addr[IAW-1:0]] <= ld_data;
        end
    end

    assign pc_o    = st_q.pc;
    assign instr_o = instr;
    assign wb_en   = reg_wr;
    assign wb_addr = wb_dst;
    assign wb_data = wb_val;
    assign st_en   = mem_wr;
    assign st_addr = alu_y;
    assign st_data = rd2;
    assign ovf_o   = alu_ovf;

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.jump && !take_br) |=> st_q.pc == $past(st_q.pc) + 32'd4)
        else $error("sequential pc step wrong");

    assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
        take_br |=> st_q.pc == $past(br_tgt))
        else $error("taken branch missed its target");

    assert_jump_low_bits_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> st_q.pc[27:0] == {$past(instr[25:0]), 2'b00})
        else $error("jump target low bits wrong");

    assert_store_lands_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> dmem_q[$past(alu_y[DAW+1:2])] == $past(rd2))
        else $error("store did not reach the data store");

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);
    localparam int LAW = (IAW > DAW) ? IAW : DAW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_we = 1'b0;
    logic           ld_dmem = 1'b0;
    logic [LAW-1:0] ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [31:0]    pc_o, instr_o, wb_data, st_addr, st_data;
    logic [4:0]     wb_addr;
    logic           wb_en, st_en, ovf_o;

    always #10 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_sc_core (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .st_en(st_en),
        .st_addr(st_addr), .st_data(st_data), .ovf_o(ovf_o)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pc;
    logic [31:0] m_reg  [32];
    logic [31:0] m_dmem [DW];
    logic [31:0] m_imem [IW];
    string       pclbl;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] f);
        return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, f};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction

    function automatic logic [31:0] rand_instr();
        int          k  = int'($urandom % 11);
        int          s  = int'($urandom % 10);
        int          t  = int'($urandom % 10);
        int          d  = int'($urandom % 10);
        int          off;
        logic [5:0]  bad [4] = '{6'b001000, 6'b001101, 6'b100000, 6'b111111};
        case (k)
            0: return enc_r(s, t, d, 6'b100000);
            1: return enc_r(s, t, d, 6'b100010);
            2: return enc_r(s, t, d, 6'b100100);
            3: return enc_r(s, t, d, 6'b100101);
            4: return enc_r(s, t, d, 6'b101010);
            5: return enc_i(6'b100011, s, t, 16'(4 * ($urandom % DW)));
            6: return enc_i(6'b101011, s, t, 16'(4 * ($urandom % DW)));
            7: begin
                off = int'($urandom % 7) - 3;
                return enc_i(6'b000100, s, t, off[15:0]);
            end
            8: return {6'b000010, 26'($urandom % IW)};
            9: return enc_r(s, t, d, 6'b000000);
            default: return {bad[$urandom % 4], 26'($urandom)};
        endcase
    endfunction

    task automatic load_word(input bit to_dmem, input int idx, input logic [31:0] val);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_dmem = to_dmem;
        ld_addr = LAW'(idx);
        ld_data = val;
    endtask

    task automatic step_and_check();
        logic [31:0] ins, a, b, sx, addr, e_val, e_sa, e_sd, e_np, r;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, e_dst;
        logic        e_we, e_st, c_ovf, e_ovf;
        string       lbl, nlbl;
        ins = m_imem[m_pc[IAW+1:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a = m_reg[rs]; b = m_reg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        e_we = 0; e_st = 0; c_ovf = 0; e_ovf = 0;
        e_dst = 0; e_val = 0; e_sa = 0; e_sd = 0;
        e_np = m_pc + 32'd4;
        lbl = "R10"; nlbl = "R2";
        case (op)
            6'b000000: begin
                e_dst = rd;
                case (fn)
                    6'b100000: begin
                        r = a + b; e_we = 1; e_val = r; c_ovf = 1; lbl = "R3";
                        e_ovf = (a[31] == b[31]) && (r[31] != a[31]);
                    end
                    6'b100010: begin
                        r = a - b; e_we = 1; e_val = r; c_ovf = 1; lbl = "R3";
                        e_ovf = (a[31] != b[31]) && (r[31] != a[31]);
                    end
                    6'b100100: begin e_we = 1; e_val = a & b; lbl = "R3"; end
                    6'b100101: begin e_we = 1; e_val = a | b; lbl = "R3"; end
                    6'b101010: begin
                        e_we = 1; lbl = "R4";
                        e_val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    end
                    default: lbl = "R10";
                endcase
            end
            6'b100011: begin
                addr = a + sx; e_we = 1; e_dst = rt;
                e_val = m_dmem[addr[DAW+1:2]];
                lbl = (m_pc < 32'd28) ? "R11" : "R5";
            end
            6'b101011: begin
                e_st = 1; e_sa = a + sx; e_sd = b; lbl = "R6";
            end
            6'b000100: begin
                lbl = "R7"; nlbl = "R7";
                if (a == b) e_np = m_pc + 32'd4 + {sx[29:0], 2'b00};
            end
            6'b000010: begin
                lbl = "R8"; nlbl = "R8";
                e_np = {e_np[31:28], ins[25:0], 2'b00};
            end
            default: lbl = "R10";
        endcase
        if (e_we && e_dst == 5'd0) begin
            e_we = 0;
            lbl = "R9";
        end

        chk(pc_o === m_pc, pclbl, "pc", pc_o, m_pc);
        chk(instr_o === ins, "R11", "fetched word", instr_o, ins);
        chk(wb_en === e_we, lbl, "wb_en", 32'(wb_en), 32'(e_we));
        if (e_we) begin
            chk(wb_addr === e_dst, lbl, "wb_addr", 32'(wb_addr), 32'(e_dst));
            chk(wb_data === e_val, lbl, "wb_data", wb_data, e_val);
        end
        chk(st_en === e_st, lbl, "st_en", 32'(st_en), 32'(e_st));
        if (e_st) begin
            chk(st_addr === e_sa, "R6", "st_addr", st_addr, e_sa);
            chk(st_data === e_sd, "R6", "st_data", st_data, e_sd);
        end
        if (c_ovf) begin
            chk(ovf_o === e_ovf, "R3", "ovf", 32'(ovf_o), 32'(e_ovf));
        end

        if (e_we) m_reg[e_dst] = e_val;
        if (e_st) m_dmem[e_sa[DAW+1:2]] = e_sd;
        m_pc  = e_np;
        pclbl = nlbl;
    endtask

    task automatic run_round(input int cycles);
        logic [31:0] pre [18];
        rst = 1'b1;
        for (int i = 0; i < DW; i++) m_dmem[i] = $urandom;
        m_dmem[0] = 32'h7fff_ffff;
        m_dmem[1] = 32'h8000_0000;
        m_dmem[2] = 32'hffff_ffff;
        m_dmem[3] = 32'd1;
        m_dmem[4] = 32'd1;
        m_dmem[5] = 32'h1234_5678;
        for (int k = 0; k < 7; k++) pre[k] = enc_i(6'b100011, 0, k + 1, 16'(4 * k));
        pre[7]  = enc_r(1, 4, 8, 6'b100000);          // overflowing add
        pre[8]  = enc_r(2, 4, 9, 6'b100010);          // overflowing subtract
        pre[9]  = enc_r(2, 1, 8, 6'b101010);          // signed less: 1
        pre[10] = enc_r(1, 2, 9, 6'b101010);          // signed less: 0
        pre[11] = enc_r(1, 1, 0, 6'b100000);          // write to register 0
        pre[12] = enc_i(6'b000100, 4, 5, 16'd1);      // taken branch over next
        pre[13] = {6'b001000, 26'h3ff_ffff};          // unsupported
        pre[14] = enc_i(6'b101011, 0, 6, 16'd8);      // store r6 to word 2
        pre[15] = enc_i(6'b100011, 0, 7, 16'd8);      // load it back
        pre[16] = {6'b000010, 26'd18};                // jump over next
        pre[17] = enc_r(1, 1, 1, 6'b100000);          // skipped
        for (int i = 0; i < IW; i++) m_imem[i] = (i < 18) ? pre[i] : rand_instr();
        for (int i = 0; i < DW; i++) load_word(1'b1, i, m_dmem[i]);
        for (int i = 0; i < IW; i++) load_word(1'b0, i, m_imem[i]);
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        #1;
        chk(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(wb_en === 1'b0, "R1", "wb_en in reset", 32'(wb_en), 32'd0);
        chk(st_en === 1'b0, "R1", "st_en in reset", 32'(st_en), 32'd0);
        rst = 1'b0;
        #1;
        m_pc = 32'd0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        pclbl = "R1";
        for (int c = 0; c < cycles; c++) begin
            step_and_check();
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        void'($urandom(32'd7719));
        for (int r = 0; r < 3; r++) run_round(400);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL all watchdog actual=%0d expected=%0d", 20000, 2000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule